// File: doc/BRIEF.md
# Sampled Phase-Frequency Detector with Lock Indicator

This block compares the rising edges of two already synchronized inputs, a signal input and a feedback (comparator) input, on a fast system clock. Its outputs drive an external charge pump. It asserts an up request when the signal edge arrives first and a down request when the feedback edge arrives first. It releases the output to a high-impedance state once the later edge is seen. When the signal input runs faster than the feedback, up dominates each cycle. When it runs slower, or stops entirely, down dominates. The loop is therefore pushed towards equal phase and frequency, and the oscillator falls to its lowest frequency when the signal is absent.

The drive state is held as an explicit three-valued code: idle/high-impedance, up, or down. An output-enable is high only while one request is active. A phase-error pulse, the OR of both requests, is timed in system-clock cycles. A registered lock flag rises after a programmable number of consecutive feedback periods whose error pulse stays within a threshold width given at a port. Lock falls on the first over-wide pulse, or when feedback edges stop for longer than a timeout.

Top module: `sampled_pfd`

## Requirements
- R1: With equal frequencies and the signal edge leading by d cycles (d ≥ 1), `up_o` is high for exactly d cycles per period and `dn_o` stays low.
- R2: With equal frequencies and the signal edge lagging by d cycles (d ≥ 1), `dn_o` is high for exactly d cycles per period and `up_o` stays low.
- R3: When the signal input has the shorter period, `up_o` is high for more than half of every common repetition interval and `dn_o` never rises.
- R4: When the signal input has the longer period, `dn_o` is high for more than half of every common repetition interval and `up_o` never rises.
- R5: With both edges in the same system-clock cycle, no request is raised: `up_o`, `dn_o` and `oe_o` stay low (high-impedance).
- R6: With no rising edges on `sig_i`, `dn_o` stays high continuously once a feedback edge has been seen.
- R7: There is no dead zone. A one-cycle phase difference gives a request pulse one cycle wide in every period.
- R8: `oe_o` is 1 exactly when one of `up_o` and `dn_o` is 1, and `up_o` and `dn_o` are never 1 together.
- R9: `perr_o` equals `up_o` OR `dn_o` in every cycle.
- R10: `lock_o` rises only in the cycle after a feedback rising edge. It rises after LOCK_PERIODS consecutive feedback periods in which every error pulse is at most `thr_i` cycles wide. A width equal to `thr_i` still qualifies.
- R11: A pulse wider than `thr_i` drops `lock_o` and prevents it from rising.
- R12: If no feedback rising edge is seen for more than TIMEOUT_CYC+1 cycles, `lock_o` is low.
- R13: Synchronous active-high `rst` makes `up_o`, `dn_o`, `oe_o`, `perr_o` and `lock_o` all 0 in the cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_i | input | 1 | Signal (reference) input, already synchronized |
| cmp_i | input | 1 | Feedback (comparator) input, already synchronized |
| thr_i | input | WIDTH_W | Largest error-pulse width, in cycles, that counts as locked |
| up_o | output | 1 | Charge-pump source request |
| dn_o | output | 1 | Charge-pump sink request |
| oe_o | output | 1 | Output driven; low means high-impedance |
| perr_o | output | 1 | Phase-error pulse |
| lock_o | output | 1 | Registered lock indication |

## Verification
The bench builds the block with WIDTH_W = 6, LOCK_PERIODS = 4 and TIMEOUT_CYC = 40, and drives both inputs with a 16-cycle period. A lock therefore forms within a few dozen cycles, and a stopped feedback input expires the timeout well inside one test. The threshold is set on either side of the programmed phase offsets, so both the equal-width boundary and the first over-wide pulse are exercised. Periods of 10 and 16 cycles give an 80-cycle common interval, so the faster and slower frequency cases repeat exactly within a short window.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Indices of the two compared inputs in the edge-detector vector
    localparam int unsigned SRC_SIG = 0;
    localparam int unsigned SRC_CMP = 1;
    localparam int unsigned NUM_SRC = 2;

    // Explicit charge-pump drive code
    typedef enum logic [1:0] {
        DRV_HIZ = 2'b00,
        DRV_UP  = 2'b01,
        DRV_DN  = 2'b10
    } drive_e;

    typedef struct packed {
        logic sig_rise;
        logic cmp_rise;
    } edges_t;

    typedef struct packed {
        logic up_pend;
        logic dn_pend;
    } flags_t;

    // Merge new edges into pending flags; once both are pending they cancel
    function automatic flags_t flags_next(flags_t cur, edges_t e);
        flags_t m;
        m.up_pend = cur.up_pend | e.sig_rise;
        m.dn_pend = cur.dn_pend | e.cmp_rise;
        if (m.up_pend && m.dn_pend) begin
            m = '0;
        end
        return m;
    endfunction

    function automatic drive_e flags_to_drive(flags_t f);
        drive_e d;
        unique case ({f.dn_pend, f.up_pend})
            2'b01:   d = DRV_UP;
            2'b10:   d = DRV_DN;
            default: d = DRV_HIZ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pfd_edge_detect.sv
module pfd_edge_detect #(
    parameter int unsigned NUM = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] din,
    output logic [NUM-1:0] rise
);

    for (genvar g = 0; g < NUM; g++) begin : g_lane
        logic prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
            end else begin
                prev_q <= din[g];
            end
        end

        assign rise[g] = din[g] & ~prev_q;
    end

endmodule

// File: rtl/pfd_flag_core.sv
module pfd_flag_core
    import pfd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  edges_t edg,
    output drive_e drive
);

    flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_next(flags_q, edg);
        end
    end

    assign drive = flags_to_drive(flags_q);

endmodule

// File: rtl/pfd_pulse_width.sv
module pfd_pulse_width #(
    parameter int unsigned WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               perr,
    input  logic [WIDTH_W-1:0] thr,
    output logic               too_wide
);

    localparam logic [WIDTH_W-1:0] CNT_MAX = {WIDTH_W{1'b1}};

    logic [WIDTH_W-1:0] cnt_q;
    logic               pulse_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (perr) begin
            cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // A nonzero count while the pulse is low marks its falling edge;
    // the count then holds the finished width in cycles.
    assign pulse_end = ~perr & (cnt_q != '0);

    // Flag a running pulse as soon as it is sure to exceed the threshold,
    // and a finished one whose measured width exceeds it.
    assign too_wide = (perr & (cnt_q >= thr)) | (pulse_end & (cnt_q > thr));

endmodule

// File: rtl/pfd_lock_monitor.sv
module pfd_lock_monitor #(
    parameter int unsigned LOCK_PERIODS = 8,
    parameter int unsigned TIMEOUT_CYC  = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp_rise,
    input  logic too_wide,
    output logic lock
);

    localparam int unsigned GW = $clog2(LOCK_PERIODS + 1);
    localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [GW-1:0] GOOD_MAX  = GW'(LOCK_PERIODS);
    localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_PERIODS - 1);
    localparam logic [TW-1:0] TMO_MAX   = TW'(TIMEOUT_CYC);

    logic [GW-1:0] good_q;
    logic [TW-1:0] idle_q;
    logic          viol_q;
    logic          lock_q;
    logic          expired;
    logic          fault;

    assign expired = (idle_q == TMO_MAX);
    assign fault   = too_wide | expired;

    always_ff @(posedge clk) begin
        if (rst) begin
            good_q <= '0;
            idle_q <= '0;
            viol_q <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            // Cycles since the last feedback edge, saturating at the limit
            if (cmp_rise) begin
                idle_q <= '0;
            end else if (!expired) begin
                idle_q <= idle_q + 1'b1;
            end

            // A violation marks the current feedback period bad
            viol_q <= cmp_rise ? 1'b0 : (viol_q | fault);

            if (cmp_rise) begin
                if (viol_q || fault) begin
                    good_q <= '0;
                end else if (good_q != GOOD_MAX) begin
                    good_q <= good_q + 1'b1;
                end
            end else if (fault) begin
                good_q <= '0;
            end

            if (fault) begin
                lock_q <= 1'b0;
            end else if (cmp_rise && !viol_q && (good_q >= GOOD_LAST)) begin
                lock_q <= 1'b1;
            end
        end
    end

    assign lock = lock_q;

endmodule

// File: rtl/sampled_pfd.sv
module sampled_pfd
    import pfd_pkg::*;
#(
    parameter int unsigned WIDTH_W      = 8,
    parameter int unsigned LOCK_PERIODS = 8,
    parameter int unsigned TIMEOUT_CYC  = 4096
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sig_i,
    input  logic               cmp_i,
    input  logic [WIDTH_W-1:0] thr_i,
    output logic               up_o,
    output logic               dn_o,
    output logic               oe_o,
    output logic               perr_o,
    output logic               lock_o
);

    logic [NUM_SRC-1:0] raw_in;
    logic [NUM_SRC-1:0] rise;
    edges_t             edg;
    drive_e             drive;
    logic               perr;
    logic               too_wide;

    assign raw_in[SRC_SIG] = sig_i;
    assign raw_in[SRC_CMP] = cmp_i;

    pfd_edge_detect #(
        .NUM (NUM_SRC)
    ) i_edges (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .rise (rise)
    );

    assign edg.sig_rise = rise[SRC_SIG];
    assign edg.cmp_rise = rise[SRC_CMP];

    pfd_flag_core i_core (
        .clk   (clk),
        .rst   (rst),
        .edg   (edg),
        .drive (drive)
    );

    assign up_o = (drive == DRV_UP);
    assign dn_o = (drive == DRV_DN);
    assign oe_o = (drive != DRV_HIZ);
    assign perr = up_o | dn_o;
    assign perr_o = perr;

    pfd_pulse_width #(
        .WIDTH_W (WIDTH_W)
    ) i_width (
        .clk      (clk),
        .rst      (rst),
        .perr     (perr),
        .thr      (thr_i),
        .too_wide (too_wide)
    );

    pfd_lock_monitor #(
        .LOCK_PERIODS (LOCK_PERIODS),
        .TIMEOUT_CYC  (TIMEOUT_CYC)
    ) i_lock (
        .clk      (clk),
        .rst      (rst),
        .cmp_rise (edg.cmp_rise),
        .too_wide (too_wide),
        .lock     (lock_o)
    );

endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
    parameter int unsigned TIMEOUT_CYC = 4096
) (
    input logic clk,
    input logic rst,
    input logic sig_i,
    input logic cmp_i,
    input logic up_o,
    input logic dn_o,
    input logic oe_o,
    input logic perr_o,
    input logic lock_o
);

    localparam int unsigned QW = $clog2(TIMEOUT_CYC + 3) + 1;
    localparam logic [QW-1:0] Q_LIMIT = QW'(TIMEOUT_CYC + 1);

    logic          cmp_d1;
    logic          cmp_edge_d;
    logic [QW-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_d1     <= 1'b0;
            cmp_edge_d <= 1'b0;
            quiet_q    <= '0;
        end else begin
            cmp_d1     <= cmp_i;
            cmp_edge_d <= cmp_i & ~cmp_d1;
            if (cmp_i && !cmp_d1) begin
                quiet_q <= '0;
            end else if (quiet_q != Q_LIMIT) begin
                quiet_q <= quiet_q + 1'b1;
            end
        end
    end

    AST_LEAD_UP: assert property (@(posedge clk) disable iff (rst)
        ($rose(sig_i) && !$rose(cmp_i) && !dn_o) |=> up_o); // R1

    AST_LAG_DN: assert property (@(posedge clk) disable iff (rst)
        ($rose(cmp_i) && !$rose(sig_i) && !up_o) |=> dn_o); // R2

    AST_SAME_EDGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($rose(sig_i) && $rose(cmp_i) && !up_o && !dn_o) |=> (!up_o && !dn_o)); // R5

    AST_NO_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(up_o && dn_o)); // R8

    AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        oe_o == (up_o ^ dn_o)); // R8

    AST_PERR_OR: assert property (@(posedge clk) disable iff (rst)
        perr_o == (up_o | dn_o)); // R9

    AST_LOCK_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> cmp_edge_d); // R10

    AST_TIMEOUT_DROP: assert property (@(posedge clk) disable iff (rst)
        (quiet_q == Q_LIMIT) |-> !lock_o); // R12

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!up_o && !dn_o && !oe_o && !perr_o && !lock_o)); // R13

endmodule

bind sampled_pfd pfd_checker #(
    .TIMEOUT_CYC (TIMEOUT_CYC)
) i_pfd_checker (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (sig_i),
    .cmp_i  (cmp_i),
    .up_o   (up_o),
    .dn_o   (dn_o),
    .oe_o   (oe_o),
    .perr_o (perr_o),
    .lock_o (lock_o)
);

// File: tb/test_sampled_pfd.sv
module test_sampled_pfd;

    localparam int W     = 6;
    localparam int NLOCK = 4;
    localparam int TMO   = 40;
    localparam int P     = 16;
    localparam int NVEC  = 8;

    // Stimulus table: feedback delay (positive = signal leads) and threshold
    localparam int V_OFF [NVEC] = '{0, 1, -1, 3, -3, 2, 5, -5};
    localparam int V_THR [NVEC] = '{2, 2, 2, 2, 3, 2, 4, 6};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sig_i = 1'b0;
    logic         cmp_i = 1'b0;
    logic [W-1:0] thr_i = '0;
    logic         up_o, dn_o, oe_o, perr_o, lock_o;

    int n_cmp = 0;
    int n_bad = 0;
    int c = 0;
    int sig_per = P;
    int cmp_per = P;
    int cmp_off = 0;
    bit sig_run = 1'b1;
    bit cmp_run = 1'b1;
    int win_lo = 0;
    int win_hi = 0;
    int up_cnt = 0;
    int dn_cnt = 0;
    int both_bad = 0;
    int oe_bad = 0;
    int perr_bad = 0;

    always #4 clk = ~clk;

    sampled_pfd #(
        .WIDTH_W      (W),
        .LOCK_PERIODS (NLOCK),
        .TIMEOUT_CYC  (TMO)
    ) i_sampled_pfd (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (sig_i),
        .cmp_i  (cmp_i),
        .thr_i  (thr_i),
        .up_o   (up_o),
        .dn_o   (dn_o),
        .oe_o   (oe_o),
        .perr_o (perr_o),
        .lock_o (lock_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Advance n cycles: sample outputs, then drive the next input values
    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            if (!rst) begin
                if (up_o && dn_o) both_bad++;
                if (oe_o != (up_o ^ dn_o)) oe_bad++;
                if (perr_o != (up_o | dn_o)) perr_bad++;
            end
            if (c >= win_lo && c < win_hi) begin
                up_cnt += int'(up_o);
                dn_cnt += int'(dn_o);
            end
            if (sig_run) sig_i = (c % sig_per) < (sig_per / 2);
            if (cmp_run) cmp_i = ((c - cmp_off + 64 * cmp_per) % cmp_per) < (cmp_per / 2);
            c++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sig_i = 1'b0;
        cmp_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        c = 0;
        sig_run = 1'b1;
        cmp_run = 1'b1;
        up_cnt = 0;
        dn_cnt = 0;
        win_lo = 0;
        win_hi = 0;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        // R13: state held in reset from time zero
        repeat (3) @(negedge clk);
        check(!up_o && !dn_o && !oe_o && !perr_o && !lock_o, "R13", "outputs in reset",
              int'({up_o, dn_o, oe_o, perr_o, lock_o}), 0);

        // Table walk: equal frequencies, various phase offsets and thresholds
        for (int i = 0; i < NVEC; i++) begin
            int exp_up;
            int exp_dn;
            int mag;
            cmp_off = V_OFF[i];
            thr_i = W'(V_THR[i]);
            sig_per = P;
            cmp_per = P;
            do_reset();
            win_lo = 4 * P;
            win_hi = 5 * P;
            exp_up = (V_OFF[i] > 0) ? V_OFF[i] : 0;
            exp_dn = (V_OFF[i] < 0) ? -V_OFF[i] : 0;
            mag = exp_up + exp_dn;
            step(40);
            check(lock_o == 1'b0, "R10", $sformatf("lock early, vector %0d", i),
                  int'(lock_o), 0);
            step(8 * P - 40);
            // R1 lead, R2 lag, R5 coincident, R7 one-cycle offset
            check(up_cnt == exp_up, (V_OFF[i] == 0) ? "R5" : (mag == 1 ? "R7" : "R1"),
                  $sformatf("up cycles, vector %0d", i), up_cnt, exp_up);
            check(dn_cnt == exp_dn, (V_OFF[i] == 0) ? "R5" : (mag == 1 ? "R7" : "R2"),
                  $sformatf("down cycles, vector %0d", i), dn_cnt, exp_dn);
            // R10 lock at width <= threshold, R11 no lock above it
            check(lock_o == (mag <= V_THR[i]), (mag <= V_THR[i]) ? "R10" : "R11",
                  $sformatf("lock, vector %0d", i), int'(lock_o), int'(mag <= V_THR[i]));
        end

        // R3: signal input faster
        thr_i = W'(2);
        cmp_off = 0;
        sig_per = 10;
        cmp_per = 16;
        do_reset();
        win_lo = 80;
        win_hi = 160;
        step(170);
        check(up_cnt * 2 > 80, "R3", "up cycles in 80", up_cnt, 41);
        check(dn_cnt == 0, "R3", "down cycles in 80", dn_cnt, 0);

        // R4: signal input slower
        sig_per = 16;
        cmp_per = 10;
        do_reset();
        win_lo = 80;
        win_hi = 160;
        step(170);
        check(dn_cnt * 2 > 80, "R4", "down cycles in 80", dn_cnt, 41);
        check(up_cnt == 0, "R4", "up cycles in 80", up_cnt, 0);

        // R6: no signal transitions
        sig_per = P;
        cmp_per = P;
        do_reset();
        sig_run = 1'b0;
        win_lo = 32;
        win_hi = 96;
        step(100);
        check(dn_cnt == 64, "R6", "down cycles in 64", dn_cnt, 64);
        check(up_cnt == 0, "R6", "up cycles in 64", up_cnt, 0);

        // R11: lock drops once the phase slips beyond the threshold
        thr_i = W'(2);
        cmp_off = 0;
        do_reset();
        step(80);
        check(lock_o == 1'b1, "R10", "lock before slip", int'(lock_o), 1);
        cmp_off = 5;
        step(40);
        check(lock_o == 1'b0, "R11", "lock after slip", int'(lock_o), 0);

        // R12: lock drops when feedback edges stop
        cmp_off = 0;
        do_reset();
        step(80);
        check(lock_o == 1'b1, "R12", "lock before stop", int'(lock_o), 1);
        sig_run = 1'b0;
        cmp_run = 1'b0;
        step(20);
        check(lock_o == 1'b1, "R12", "lock inside timeout", int'(lock_o), 1);
        step(20);
        check(lock_o == 1'b0, "R12", "lock after timeout", int'(lock_o), 0);

        // R13: reset in the middle of an up pulse
        cmp_off = 5;
        do_reset();
        step(2 * P + 2);
        check(up_o == 1'b1, "R13", "up before reset", int'(up_o), 1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!up_o && !dn_o && !oe_o && !perr_o && !lock_o, "R13", "outputs after reset",
              int'({up_o, dn_o, oe_o, perr_o, lock_o}), 0);
        rst = 1'b0;

        // R8 and R9: invariants gathered over every sampled cycle
        check(both_bad == 0, "R8", "cycles with up and down", both_bad, 0);
        check(oe_bad == 0, "R8", "cycles with wrong enable", oe_bad, 0);
        check(perr_bad == 0, "R9", "cycles with wrong error pulse", perr_bad, 0);

        finish_run();
    end

endmodule